// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block chooses the next control-store address for a microcoded 8-bit processor and delivers the microinstruction found there. It holds a micro program counter and, once per clock, picks the following address from one of several sources: the counter plus one, a loadable fetch-routine entry register, a 256-entry dispatch table indexed by the current macro opcode, a branch target carried inside the microinstruction, or zero while reset is held. The word at the chosen address is read from a control store and captured into the microinstruction register in the same clock edge, so the counter and the word it points at always change together.

The lowest byte of every microinstruction is its micro-opcode. Two codes redirect the sequence: one jumps to the fetch routine, the other jumps through the dispatch table. A contiguous group of codes tests the condition flags and branches when the test holds. Codes in the unused part of that group are treated as faults: the sequencer freezes and raises a sticky error flag. All other codes belong to the datapath and simply advance the counter. The control store and the dispatch table are constant images given as parameters; the datapath and ALU sit outside this block.

Top module: `useq_sequencer`

## Requirements
- R1: On a rising edge with `rst` high the micro PC becomes 0, the microinstruction register takes control-store word 0, the error flag clears and the fetch-entry register clears; reset outranks every other source.
- R2: A micro-opcode outside 160..191, 254 and 255 advances the micro PC by one, wrapping from the top address to 0.
- R3: Micro-opcode 255 loads the micro PC from the fetch-entry register.
- R4: A rising edge with `fp_load` high and `rst` low stores `fp_data` in the fetch-entry register; the new value governs a fetch from the next edge on.
- R5: Micro-opcode 254 loads the micro PC from the dispatch-table entry indexed by `opcode_in`.
- R6: Micro-opcodes 160..173 test the flags `cc_in` (bit 3 N, bit 2 Z, bit 1 V, bit 0 C), in order: C clear, C set, Z set, N equals V, Z clear and N equals V, C and Z both clear, Z set or N differs from V, C or Z set, N differs from V, N set, Z clear, V clear, V set, N clear. A true test loads the branch-target field; a false one advances by one.
- R7: Micro-opcode 174 always loads the branch-target field, whatever the flags.
- R8: Micro-opcodes 175..191 hold the micro PC and set `err_out`, which stays high until reset.
- R9: The microinstruction register always holds the control-store word at the current micro PC; addresses at or above the store depth read as all zeros.
- R10: A microinstruction has the micro-opcode in bits [7:0], the branch target in bits [UPC_W+7:8] and datapath control bits above that, passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode_in | input | 8 | Macro opcode used to index the dispatch table |
| cc_in | input | 4 | Condition flags {N, Z, V, C} |
| fp_load | input | 1 | Write strobe for the fetch-entry register |
| fp_data | input | UPC_W | Value for the fetch-entry register |
| upc_out | output | UPC_W | Current micro program counter |
| uir_out | output | CTRL_W+UPC_W+8 | Current microinstruction word |
| err_out | output | 1 | Sticky fault flag for undefined test codes |

## Verification
The micro PC and the microinstruction register both move on the edge that follows the cycle in which the deciding word sits in the register, so every dispatch, fetch, branch or increment is visible one edge after its cause; the error flag rises on that same edge, and a fetch-entry write counts from the edge after the strobe. The bench drives inputs on the falling edge, lets exactly one rising edge pass per step, and samples on the next falling edge. Each vector is reached by a reset followed by one dispatch, so the word under test lands in the register after a known two edges and its successor after a third.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int UOP_W = 8;

   localparam logic [UOP_W-1:0] UOP_FETCH = 8'd255;
   localparam logic [UOP_W-1:0] UOP_DISP  = 8'd254;
   localparam logic [2:0]       TEST_GRP  = 3'b101;
   localparam logic [4:0]       TEST_LAST = 5'd14;

   typedef enum logic [2:0] {
      SRC_INC,
      SRC_FETCH,
      SRC_DISP,
      SRC_BRANCH,
      SRC_HOLD
   } nxt_src_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccf_t;

   function automatic logic test_holds(input logic [3:0] code, input ccf_t f);
      logic r;
      case (code)
         4'd0:    r = !f.c;
         4'd1:    r = f.c;
         4'd2:    r = f.z;
         4'd3:    r = (f.n == f.v);
         4'd4:    r = !f.z && (f.n == f.v);
         4'd5:    r = !f.c && !f.z;
         4'd6:    r = f.z || (f.n != f.v);
         4'd7:    r = f.c || f.z;
         4'd8:    r = (f.n != f.v);
         4'd9:    r = f.n;
         4'd10:   r = !f.z;
         4'd11:   r = !f.v;
         4'd12:   r = f.v;
         4'd13:   r = !f.n;
         4'd14:   r = 1'b1;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4,
   parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   localparam int SPAN = 1 << ADDR_W;

   if (DEPTH < 1 || DEPTH > SPAN) begin : g_bad_depth
      $error("useq_rom: DEPTH must lie in 1..2**ADDR_W");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("useq_rom: DATA_W must be positive");
   end

   if (DEPTH < SPAN) begin : g_partial
      always_comb begin
         if (int'(addr) < DEPTH) data = IMAGE[int'(addr)*DATA_W +: DATA_W];
         else                    data = '0;
      end
   end else begin : g_full
      assign data = IMAGE[int'(addr)*DATA_W +: DATA_W];
   end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
   import useq_pkg::*;
(
   input  logic [UOP_W-1:0] uop,
   input  ccf_t             ccf,
   output nxt_src_e         src,
   output logic             bad_op
);

   logic in_test_grp;
   logic test_defined;

   assign in_test_grp  = (uop[7:5] == TEST_GRP);
   assign test_defined = (uop[4:0] <= TEST_LAST);

   always_comb begin
      src    = SRC_INC;
      bad_op = 1'b0;
      if (uop == UOP_FETCH) begin
         src = SRC_FETCH;
      end else if (uop == UOP_DISP) begin
         src = SRC_DISP;
      end else if (in_test_grp) begin
         if (test_defined) begin
            src = test_holds(uop[3:0], ccf) ? SRC_BRANCH : SRC_INC;
         end else begin
            src    = SRC_HOLD;
            bad_op = 1'b1;
         end
      end
   end

   always_comb begin
      if (!in_test_grp) assert (!bad_op) else $error("p_fault_scope_r8: fault outside test group");
   end

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
   import useq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         rst,
   input  nxt_src_e     src,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] fetch_entry,
   input  logic [W-1:0] disp_entry,
   input  logic [W-1:0] branch_to,
   output logic [W-1:0] nxt
);

   always_comb begin
      if (rst) begin
         nxt = '0;
      end else begin
         case (src)
            SRC_INC:    nxt = cur + 1'b1;
            SRC_FETCH:  nxt = fetch_entry;
            SRC_DISP:   nxt = disp_entry;
            SRC_BRANCH: nxt = branch_to;
            SRC_HOLD:   nxt = cur;
            default:    nxt = cur;
         endcase
      end
   end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
   import useq_pkg::*;
#(
   parameter int UPC_W    = 8,
   parameter int CS_DEPTH = 64,
   parameter int CTRL_W   = 8,
   parameter logic [CS_DEPTH*(CTRL_W+UPC_W+UOP_W)-1:0] CS_IMAGE   = '0,
   parameter logic [(1<<UOP_W)*UPC_W-1:0]              DISP_IMAGE = '0
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [UOP_W-1:0]                opcode_in,
   input  logic [3:0]                      cc_in,
   input  logic                            fp_load,
   input  logic [UPC_W-1:0]                fp_data,
   output logic [UPC_W-1:0]                upc_out,
   output logic [CTRL_W+UPC_W+UOP_W-1:0]   uir_out,
   output logic                            err_out
);

   localparam int WORD_W     = CTRL_W + UPC_W + UOP_W;
   localparam int DISP_DEPTH = 1 << UOP_W;
   localparam int TGT_LO     = UOP_W;
   localparam int TGT_HI     = UOP_W + UPC_W - 1;

   if (UPC_W < 2 || UPC_W > 16) begin : g_bad_upc
      $error("useq_sequencer: UPC_W must lie in 2..16");
   end
   if (CS_DEPTH < 1 || CS_DEPTH > (1 << UPC_W)) begin : g_bad_cs
      $error("useq_sequencer: CS_DEPTH must lie in 1..2**UPC_W");
   end
   if (CTRL_W < 1) begin : g_bad_ctrl
      $error("useq_sequencer: CTRL_W must be positive");
   end

   logic [UPC_W-1:0]  upc_q;
   logic [WORD_W-1:0] uir_q;
   logic [UPC_W-1:0]  fp_q;
   logic              err_q;

   logic [UPC_W-1:0]  upc_nxt;
   logic [WORD_W-1:0] cs_word;
   logic [UPC_W-1:0]  disp_word;
   nxt_src_e          src;
   logic              bad_op;

   useq_decode u_dec (
      .uop    (uir_q[UOP_W-1:0]),
      .ccf    (ccf_t'(cc_in)),
      .src    (src),
      .bad_op (bad_op)
   );

   useq_nextaddr #(.W(UPC_W)) u_nxt (
      .rst         (rst),
      .src         (src),
      .cur         (upc_q),
      .fetch_entry (fp_q),
      .disp_entry  (disp_word),
      .branch_to   (uir_q[TGT_HI:TGT_LO]),
      .nxt         (upc_nxt)
   );

   useq_rom #(
      .DATA_W (WORD_W),
      .DEPTH  (CS_DEPTH),
      .ADDR_W (UPC_W),
      .IMAGE  (CS_IMAGE)
   ) u_cstore (
      .addr (upc_nxt),
      .data (cs_word)
   );

   useq_rom #(
      .DATA_W (UPC_W),
      .DEPTH  (DISP_DEPTH),
      .ADDR_W (UOP_W),
      .IMAGE  (DISP_IMAGE)
   ) u_disp (
      .addr (opcode_in),
      .data (disp_word)
   );

   always_ff @(posedge clk) begin
      upc_q <= upc_nxt;
      uir_q <= cs_word;
   end

   always_ff @(posedge clk) begin
      if (rst)          fp_q <= '0;
      else if (fp_load) fp_q <= fp_data;
   end

   always_ff @(posedge clk) begin
      if (rst)         err_q <= 1'b0;
      else if (bad_op) err_q <= 1'b1;
   end

   assign upc_out = upc_q;
   assign uir_out = uir_q;
   assign err_out = err_q;

   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> (upc_q == '0) && !err_q && (fp_q == '0));

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (src == SRC_INC) |=> (upc_q == $past(upc_q) + 1'b1));

   p_fetch_r3: assert property (@(posedge clk) disable iff (rst)
      (src == SRC_FETCH) |=> (upc_q == $past(fp_q)));

   p_fp_write_r4: assert property (@(posedge clk) disable iff (rst)
      fp_load |=> (fp_q == $past(fp_data)));

   p_dispatch_r5: assert property (@(posedge clk) disable iff (rst)
      (src == SRC_DISP) |=> (upc_q == $past(disp_word)));

   p_branch_r6: assert property (@(posedge clk) disable iff (rst)
      (src == SRC_BRANCH) |=> (upc_q == $past(uir_q[TGT_HI:TGT_LO])));

   p_always_r7: assert property (@(posedge clk) disable iff (rst)
      (uir_q[UOP_W-1:0] == 8'd174) |=> (upc_q == $past(uir_q[TGT_HI:TGT_LO])));

   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      bad_op |=> $stable(upc_q) && err_q);

   p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      err_q |=> err_q);

endmodule

// File: tb/sim_useq_sequencer.sv
`timescale 1ns/1ps
module sim_useq_sequencer;

   localparam int UPC_W = 8;
   localparam int DEPTH = 64;
   localparam int CTRL_W = 8;
   localparam int WW = CTRL_W + UPC_W + 8;

   function automatic logic [WW-1:0] cs_word(input int a);
      logic [7:0] op;
      logic [7:0] tg;
      logic [7:0] ct;
      op = 8'd0; tg = 8'd0; ct = 8'd0;
      if (a == 0) op = 8'd254;
      else if (a >= 1 && a <= 15) begin op = 8'(159 + a); tg = 8'(48 + a); end
      else if (a == 16) op = 8'd175;
      else if (a == 17) op = 8'd191;
      else if (a == 18) op = 8'd255;
      else if (a == 19) begin op = 8'd5; ct = 8'hA5; end
      else if (a == 20) op = 8'd200;
      else if (a == 21) op = 8'd159;
      else if (a == 63) op = 8'd7;
      return {ct, tg, op};
   endfunction

   function automatic logic [DEPTH*WW-1:0] build_cs();
      logic [DEPTH*WW-1:0] img;
      img = '0;
      for (int i = 0; i < DEPTH; i++) img[i*WW +: WW] = cs_word(i);
      return img;
   endfunction

   function automatic logic [256*UPC_W-1:0] build_disp();
      logic [256*UPC_W-1:0] img;
      img = '0;
      for (int i = 0; i < 256; i++) img[i*UPC_W +: UPC_W] = 8'(i) ^ 8'h15;
      return img;
   endfunction

   localparam logic [DEPTH*WW-1:0]     CS_IMG   = build_cs();
   localparam logic [256*UPC_W-1:0]    DISP_IMG = build_disp();

   // each row: {arrival address, flags {N,Z,V,C}, expected next micro PC}
   localparam int NV = 35;
   localparam logic [23:0] VEC [NV] = '{
      24'h01_00_31, 24'h01_01_02, 24'h02_01_32, 24'h02_00_03,
      24'h03_04_33, 24'h03_00_04, 24'h04_0A_34, 24'h04_08_05,
      24'h05_00_35, 24'h05_04_06, 24'h06_00_36, 24'h06_01_07,
      24'h07_08_37, 24'h07_00_08, 24'h08_01_38, 24'h08_00_09,
      24'h09_02_39, 24'h09_0A_0A, 24'h0A_08_3A, 24'h0A_00_0B,
      24'h0B_00_3B, 24'h0B_04_0C, 24'h0C_00_3C, 24'h0C_02_0D,
      24'h0D_02_3D, 24'h0D_00_0E, 24'h0E_00_3E, 24'h0E_08_0F,
      24'h0F_0F_3F, 24'h0F_00_3F, 24'h13_00_14, 24'h14_00_15,
      24'h15_00_16, 24'h3F_00_40, 24'hFF_00_00
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [7:0]       opcode_in = 8'd0;
   logic [3:0]       cc_in = 4'd0;
   logic             fp_load = 1'b0;
   logic [UPC_W-1:0] fp_data = '0;
   logic [UPC_W-1:0] upc_out;
   logic [WW-1:0]    uir_out;
   logic             err_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   useq_sequencer #(
      .UPC_W      (UPC_W),
      .CS_DEPTH   (DEPTH),
      .CTRL_W     (CTRL_W),
      .CS_IMAGE   (CS_IMG),
      .DISP_IMAGE (DISP_IMG)
   ) u0 (
      .clk       (clk),
      .rst       (rst),
      .opcode_in (opcode_in),
      .cc_in     (cc_in),
      .fp_load   (fp_load),
      .fp_data   (fp_data),
      .upc_out   (upc_out),
      .uir_out   (uir_out),
      .err_out   (err_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reset, then dispatch to address a; returns at the falling edge after arrival
   task automatic go(input logic [7:0] a, input logic [3:0] fl,
                     input logic ld, input logic [7:0] fd);
      @(negedge clk); rst = 1'b1; fp_load = 1'b0;
      @(negedge clk); rst = 1'b0; opcode_in = a ^ 8'h15; cc_in = fl;
      fp_load = ld; fp_data = fd;
      @(negedge clk); fp_load = 1'b0;
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      chk("R1 reset upc", 32'(upc_out), 32'd0);
      chk("R1 reset uir", 32'(uir_out), 32'(cs_word(0)));
      chk("R1 reset err", 32'(err_out), 32'd0);

      // table: R5 dispatch on arrival, R6/R7/R2 successor, R9 word at upc
      for (int i = 0; i < NV; i++) begin
         go(VEC[i][23:16], VEC[i][11:8], 1'b0, 8'd0);
         chk("R5 dispatch target", 32'(upc_out), 32'(VEC[i][23:16]));
         chk("R9 word at upc", 32'(uir_out), 32'(cs_word(int'(VEC[i][23:16]))));
         @(negedge clk);
         chk("R6 R7 R2 successor", 32'(upc_out), 32'(VEC[i][7:0]));
         chk("R9 successor word", 32'(uir_out), 32'(cs_word(int'(VEC[i][7:0]))));
      end

      // R4 load then R3 fetch; R10 field layout
      go(8'd18, 4'd0, 1'b1, 8'h13);
      chk("R4 arrival at fetch word", 32'(upc_out), 32'h12);
      @(negedge clk);
      chk("R3 fetch entry", 32'(upc_out), 32'h13);
      chk("R10 control field", 32'(uir_out[23:16]), 32'hA5);
      chk("R10 opcode field", 32'(uir_out[7:0]), 32'h05);
      @(negedge clk);
      chk("R2 after fetch", 32'(upc_out), 32'h14);

      // R1 reset clears the fetch entry
      go(8'd18, 4'd0, 1'b0, 8'd0);
      @(negedge clk);
      chk("R1 R3 fetch entry cleared", 32'(upc_out), 32'd0);

      // R8 undefined test code holds and latches error
      go(8'd16, 4'd0, 1'b0, 8'd0);
      chk("R8 arrival no error yet", 32'(err_out), 32'd0);
      @(negedge clk);
      chk("R8 hold upc", 32'(upc_out), 32'd16);
      chk("R8 error set", 32'(err_out), 32'd1);
      cc_in = 4'hF; opcode_in = 8'd0;
      @(negedge clk);
      chk("R8 still held", 32'(upc_out), 32'd16);
      chk("R8 error sticky", 32'(err_out), 32'd1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset from fault upc", 32'(upc_out), 32'd0);
      chk("R1 reset clears error", 32'(err_out), 32'd0);

      go(8'd17, 4'd0, 1'b0, 8'd0);
      @(negedge clk);
      chk("R8 top code holds", 32'(upc_out), 32'd17);
      chk("R8 top code error", 32'(err_out), 32'd1);
   endtask

   initial begin
      fork
         begin run_all(); done = 1'b1; end
         begin repeat (200000) @(posedge clk); end
      join_any
      disable fork;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog actual=running expected=finished");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule